// File: doc/BRIEF.md
# ADC Level Conditioning and Read Hold

This block sits between a two-slot ADC front end and a register bank. The front end takes turns between its two slots, with one slot doing a coarse pass while the other does a fine pass. Each time a pass finishes, the front end hands over a raw 12-bit code and the index of the channel it belongs to. The block turns each fine result into an 8-bit level and keeps one published level per monitor channel, six channels by default. Each step of the 8-bit level is worth twelve raw steps. A raw offset of 480 codes corresponds to level zero. Coarse results never reach the published levels.

Any channel can be marked as differential. For such a channel the front end delivers two values: the plain measured code and the measured average of the pin and its return. The block rebuilds the difference as twice the excess of the measured code over the average. A negative difference is floored at zero. The result is then scaled like any other channel.

The bus engine raises a per-channel busy line while it reads that channel's level. As long as the line is high, the published level stays fixed. The newest result that arrives during the read is kept in a shadow register. It is published on the first clock edge at which the busy line is seen low.

Top module: `adc_level_hold`

## Requirements
- R1: While reset is high and after it is released, every published level reads 0 until a fine result for that channel arrives.
- R2: A single-ended fine result with raw code c >= 480 publishes floor((c - 480 + 6) / 12), which is the scaled value rounded to nearest. Example: code 1000 gives 43.
- R3: Raw codes up to and including 485 publish 0. Code 486 publishes 1.
- R4: The level saturates at 255 for any effective value of 3534 or more. Code 3533 gives 254.
- R5: On a channel whose bit in `diff_sel` is 1, the effective value is 2 x (code - avg) when code > avg and 0 otherwise. This value is scaled as in R2 to R4.
- R6: A result with `conv_fine` low (a coarse result) leaves every published level unchanged.
- R7: While `rd_busy[i]` is high, level i does not change. The latest result received during that time is published on the first rising edge at which `rd_busy[i]` is low.
- R8: A result updates only the channel named by `conv_ch`. An index of `NUM_CH` or more changes no level.
- R9: A fine result sampled on one rising edge appears on `lvl_flat` after the second rising edge. At the first edge the old value is still shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_valid | input | 1 | A conversion result is present this cycle |
| conv_fine | input | 1 | 1 = fine result, 0 = coarse result |
| conv_ch | input | 3 | Channel index of the result |
| conv_code | input | 12 | Raw measured code |
| conv_avg | input | 12 | Raw measured average, used by differential channels only |
| diff_sel | input | 6 | Bit i = 1 marks channel i as differential |
| rd_busy | input | 6 | Bit i = 1 while the bus reads channel i |
| lvl_flat | output | 48 | Published levels; channel i occupies bits [8i+7:8i] |

## Verification
The scaling is exercised with raw codes on both sides of each rounding boundary: 485 and 486, 3533 and 3534, and full scale 4095. A fault in the offset, the half-step rounding or the clamp therefore shows up as an off-by-one level. Differential channels receive pairs with a positive excess, a negative excess and an excess large enough to saturate. These separate a missing doubling, a missing floor and a wrap-around. Further directed sequences cover coarse results, out-of-range indices, a busy channel next to an idle one, two results stacked up during a single read, and the cycle at which a result first becomes visible.

// File: rtl/adc_lvl_pkg.sv
package adc_lvl_pkg;
  localparam int unsigned NUM_CH_DEF  = 6;
  localparam int unsigned RAW_W_DEF   = 12;
  localparam int unsigned LVL_W_DEF   = 8;
  localparam int unsigned OFFSET_DEF  = 480;
  localparam int unsigned STEP_DEF    = 12;
endpackage

// File: rtl/adc_diff_rebuild.sv
module adc_diff_rebuild #(
  parameter int unsigned RAW_W = 12,
  parameter int unsigned VAL_W = RAW_W + 2
) (
  input  logic             is_diff,
  input  logic [RAW_W-1:0] code,
  input  logic [RAW_W-1:0] avg,
  output logic [VAL_W-1:0] eff_val
);
  logic [RAW_W-1:0] excess;

  always_comb begin
    excess = code - avg;
    if (!is_diff) begin
      eff_val = VAL_W'(code);
    end else if (code <= avg) begin
      eff_val = '0;
    end else begin
      eff_val = VAL_W'({excess, 1'b0});
    end
  end
endmodule

// File: rtl/adc_code_scaler.sv
module adc_code_scaler #(
  parameter int unsigned VAL_W  = 14,
  parameter int unsigned LVL_W  = 8,
  parameter int unsigned CH_W   = 3,
  parameter int unsigned OFFSET = 480,
  parameter int unsigned STEP   = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [CH_W-1:0]  in_ch,
  input  logic [VAL_W-1:0] in_val,
  output logic             out_valid,
  output logic [CH_W-1:0]  out_ch,
  output logic [LVL_W-1:0] out_lvl
);
  localparam int unsigned SUM_W    = VAL_W + 1;
  localparam int unsigned HALF     = STEP / 2;
  localparam int unsigned LVL_MAX  = (1 << LVL_W) - 1;
  localparam int unsigned SAT_MIN  = OFFSET + STEP * LVL_MAX - HALF;
  localparam int unsigned ZERO_TOP = OFFSET - HALF + STEP;

  logic [SUM_W-1:0] biased;
  logic [SUM_W-1:0] quot;
  logic [LVL_W-1:0] lvl_next;

  always_comb begin
    biased = {1'b0, in_val} + SUM_W'(HALF);
    if (biased < SUM_W'(OFFSET)) begin
      quot = '0;
    end else begin
      quot = (biased - SUM_W'(OFFSET)) / SUM_W'(STEP);
    end
    if (quot > SUM_W'(LVL_MAX)) begin
      lvl_next = LVL_W'(LVL_MAX);
    end else begin
      lvl_next = quot[LVL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ch    <= '0;
      out_lvl   <= '0;
    end else begin
      out_valid <= in_valid;
      out_ch    <= in_ch;
      out_lvl   <= lvl_next;
    end
  end

  assert_saturate_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_val >= VAL_W'(SAT_MIN)) |=> (out_lvl == LVL_W'(LVL_MAX)));

  assert_floor_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_val < VAL_W'(ZERO_TOP)) |=> (out_lvl == '0));
endmodule

// File: rtl/adc_level_slot.sv
module adc_level_slot #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic [LVL_W-1:0] upd_lvl,
  input  logic             busy,
  output logic [LVL_W-1:0] level
);
  logic [LVL_W-1:0] shadow;
  logic             pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      level  <= '0;
      shadow <= '0;
      pend   <= 1'b0;
    end else if (busy) begin
      if (upd) begin
        shadow <= upd_lvl;
        pend   <= 1'b1;
      end
    end else begin
      pend <= 1'b0;
      if (upd) begin
        level <= upd_lvl;
      end else if (pend) begin
        level <= shadow;
      end
    end
  end

  assert_hold_while_read_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(level));

  assert_pending_drains_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !pend);
endmodule

// File: rtl/adc_level_hold.sv
module adc_level_hold
  import adc_lvl_pkg::*;
#(
  parameter int unsigned NUM_CH = NUM_CH_DEF,
  parameter int unsigned RAW_W  = RAW_W_DEF,
  parameter int unsigned LVL_W  = LVL_W_DEF,
  parameter int unsigned OFFSET = OFFSET_DEF,
  parameter int unsigned STEP   = STEP_DEF,
  parameter int unsigned CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    conv_valid,
  input  logic                    conv_fine,
  input  logic [CH_W-1:0]         conv_ch,
  input  logic [RAW_W-1:0]        conv_code,
  input  logic [RAW_W-1:0]        conv_avg,
  input  logic [NUM_CH-1:0]       diff_sel,
  input  logic [NUM_CH-1:0]       rd_busy,
  output logic [NUM_CH*LVL_W-1:0] lvl_flat
);
  localparam int unsigned VAL_W = RAW_W + 2;

  logic             ch_ok;
  logic             take;
  logic             ch_diff;
  logic [VAL_W-1:0] eff_val;
  logic             sc_valid;
  logic [CH_W-1:0]  sc_ch;
  logic [LVL_W-1:0] sc_lvl;

  always_comb begin
    ch_ok   = ({1'b0, conv_ch} < (CH_W+1)'(NUM_CH));
    take    = conv_valid && conv_fine && ch_ok;
    ch_diff = 1'b0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (conv_ch == CH_W'(k)) ch_diff = diff_sel[k];
    end
  end

  adc_diff_rebuild #(.RAW_W(RAW_W), .VAL_W(VAL_W)) u_diff (
    .is_diff (ch_diff),
    .code    (conv_code),
    .avg     (conv_avg),
    .eff_val (eff_val)
  );

  adc_code_scaler #(
    .VAL_W(VAL_W), .LVL_W(LVL_W), .CH_W(CH_W), .OFFSET(OFFSET), .STEP(STEP)
  ) u_scale (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (take),
    .in_ch     (conv_ch),
    .in_val    (eff_val),
    .out_valid (sc_valid),
    .out_ch    (sc_ch),
    .out_lvl   (sc_lvl)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_slot
    logic hit;
    assign hit = sc_valid && (sc_ch == CH_W'(i));
    adc_level_slot #(.LVL_W(LVL_W)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .upd     (hit),
      .upd_lvl (sc_lvl),
      .busy    (rd_busy[i]),
      .level   (lvl_flat[i*LVL_W +: LVL_W])
    );
  end

  assert_coarse_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    !(conv_valid && conv_fine) |=> !sc_valid);

  assert_bad_index_dropped_R8: assert property (@(posedge clk) disable iff (rst)
    (conv_valid && !ch_ok) |=> !sc_valid);
endmodule

// File: tb/sim_adc_level_hold.sv
module sim_adc_level_hold;
  typedef struct packed {
    logic [2:0]  ch;
    logic [11:0] code;
    logic [11:0] avg;
    logic [7:0]  exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{3'd2, 12'd480,  12'd0,    8'd0},
    '{3'd2, 12'd485,  12'd0,    8'd0},
    '{3'd3, 12'd486,  12'd0,    8'd1},
    '{3'd4, 12'd1000, 12'd0,    8'd43},
    '{3'd5, 12'd3533, 12'd0,    8'd254},
    '{3'd5, 12'd3534, 12'd0,    8'd255},
    '{3'd2, 12'd4095, 12'd0,    8'd255},
    '{3'd3, 12'd0,    12'd0,    8'd0},
    '{3'd0, 12'd2000, 12'd1500, 8'd43},
    '{3'd1, 12'd1000, 12'd1200, 8'd0},
    '{3'd0, 12'd3000, 12'd1000, 8'd255},
    '{3'd1, 12'd1240, 12'd995,  8'd1},
    '{3'd2, 12'd1000, 12'd4000, 8'd43}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        conv_valid = 1'b0;
  logic        conv_fine = 1'b0;
  logic [2:0]  conv_ch = '0;
  logic [11:0] conv_code = '0;
  logic [11:0] conv_avg = '0;
  logic [5:0]  diff_sel = 6'b000011;
  logic [5:0]  rd_busy = '0;
  logic [47:0] lvl_flat;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  adc_level_hold u0 (
    .clk(clk), .rst(rst), .conv_valid(conv_valid), .conv_fine(conv_fine),
    .conv_ch(conv_ch), .conv_code(conv_code), .conv_avg(conv_avg),
    .diff_sel(diff_sel), .rd_busy(rd_busy), .lvl_flat(lvl_flat)
  );

  task automatic chk(input string req, input int ch, input logic [7:0] exp);
    logic [7:0] got;
    got = lvl_flat[ch*8 +: 8];
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s ch%0d got %0d expected %0d", req, ch, got, exp);
    end
  endtask

  task automatic drive(input int ch, input int code, input int avg, input bit fine);
    @(negedge clk);
    conv_valid = 1'b1;
    conv_fine  = fine;
    conv_ch    = 3'(ch);
    conv_code  = 12'(code);
    conv_avg   = 12'(avg);
    @(negedge clk);
    conv_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] snap [6];
    repeat (3) @(negedge clk);
    for (int c = 0; c < 6; c++) chk("R1 reset", c, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int c = 0; c < 6; c++) chk("R1 after release", c, 8'd0);

    // R2 R3 R4 R5 vector walk
    for (int i = 0; i < NV; i++) begin
      drive(int'(VECS[i].ch), int'(VECS[i].code), int'(VECS[i].avg), 1'b1);
      chk("R2/R3/R4/R5 vector", int'(VECS[i].ch), VECS[i].exp);
    end

    // R6: coarse result on ch4 (holds 43)
    drive(4, 2000, 0, 1'b0);
    chk("R6 coarse ignored", 4, 8'd43);

    // R8: index 6 and 7 change nothing
    for (int c = 0; c < 6; c++) snap[c] = lvl_flat[c*8 +: 8];
    drive(6, 2000, 0, 1'b1);
    drive(7, 3000, 0, 1'b1);
    for (int c = 0; c < 6; c++) chk("R8 bad index", c, snap[c]);

    // R9: latency of two edges (ch4: 43 -> 63 with code 1240)
    @(negedge clk);
    conv_valid = 1'b1; conv_fine = 1'b1; conv_ch = 3'd4; conv_code = 12'd1240; conv_avg = '0;
    @(negedge clk);
    conv_valid = 1'b0;
    chk("R9 one edge old", 4, 8'd43);
    @(negedge clk);
    chk("R9 two edges new", 4, 8'd63);

    // R7: freeze ch3 (holds 0) with two results stacked; ch2 updates meanwhile (R8)
    rd_busy[3] = 1'b1;
    drive(3, 1000, 0, 1'b1);
    drive(3, 1240, 0, 1'b1);
    drive(2, 486, 0, 1'b1);
    chk("R7 frozen", 3, 8'd0);
    chk("R8 neighbour updates", 2, 8'd1);
    repeat (4) @(negedge clk);
    chk("R7 still frozen", 3, 8'd0);
    rd_busy[3] = 1'b0;
    @(negedge clk);
    chk("R7 latest applied", 3, 8'd63);
    drive(3, 486, 0, 1'b1);
    chk("R7 normal after read", 3, 8'd1);

    // R7: result arriving on the busy-release edge wins
    rd_busy[5] = 1'b1;
    drive(5, 1000, 0, 1'b1);
    @(negedge clk);
    conv_valid = 1'b1; conv_fine = 1'b1; conv_ch = 3'd5; conv_code = 12'd486;
    @(negedge clk);
    conv_valid = 1'b0;
    rd_busy[5] = 1'b0;
    @(negedge clk);
    chk("R7 fresh result over shadow", 5, 8'd1);

    // R1: reset clears published levels again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < 6; c++) chk("R1 re-reset", c, 8'd0);

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule